// File: doc/BRIEF.md
# Triggered PWM Generator with Buffered Period and Duty

This block produces a pulse-width-modulated waveform from a 12-bit up-counter that advances on a divided prescaler enable. Two values shape the waveform. The period value P makes each period last P+1 counter steps. The duty value D gives the number of steps, counted from the start of a period, during which the output is active. Software writes both values through a single register write port. While the generator runs, a write lands in a shadow buffer, and that buffer moves into the working register only when a new period begins. The output therefore never shows a period built from a mix of old and new settings.

The generator does nothing until a start event arrives. A start event is either a one-cycle software start pulse or an edge on an external start pin. The external pin passes through a two-stage synchronizer, and a control field selects which of its edges count. A start event clears the counter and the prescaler, makes the output active, and loads the shadow values. A polarity bit can invert the pin. A stop bit returns the block to its idle state.

The controller has two states. ST_IDLE is the stopped state, where nothing counts and the output is inactive. ST_RUN is the counting state. There are four transitions. IDLE to RUN (start) happens on a start event while the stop bit is clear. RUN to RUN (restart) happens on a start event while running, and it clears the counter again. RUN to RUN (period wrap) happens when the counter passes the period value: the counter returns to zero and the shadow values load. RUN to IDLE (halt) happens whenever the stop bit is set.

Top module: `trig_pwm_gen`

## Requirements
- R1: After reset the block is in ST_IDLE. Without a start event the output stays at its inactive level whatever the settings, and with polarity 0 that level is low.
- R2: A software start pulse sampled on a clock edge, with the stop bit clear, makes the output active from that edge on. The output is active for D of every P+1 counter steps.
- R3: When D is 0 the output is never active, for any P, including P = 0.
- R4: When D is greater than P, the output is active all the time. This includes D = P+1 and the case P = 0 with D = 1.
- R5: A write to the period or duty register while running changes only its buffer. The new value takes effect at the start of the next period.
- R6: The write port selects its target by wr_sel. The code 00 selects the period, 01 the duty and 10 the control register. While the block is stopped, or while the stop bit is set, a period or duty write updates the buffer and the working value together, so the first period after a start already uses it.
- R7: The control register takes wr_data[5:0] as follows: bit 0 is stop, bits 2:1 are the edge select, bits 4:3 are the divide select, and bit 5 is polarity. With polarity 1 the pin is the inverse of the internal active state, so it is high while idle.
- R8: The edge select field works as follows. 00 ignores the external pin, 01 starts on a rising edge, 10 starts on a falling edge, and 11 starts on either edge. The pin is synchronized through two flip-flops before edge detection.
- R9: The counter advances only on pre_tick pulses. The divide select values 0, 1, 2 and 3 make one counter step take 1, 2, 4 or 8 pre_tick pulses.
- R10: Setting the stop bit returns the block to ST_IDLE with the output inactive. Start events are ignored while the stop bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 period, 01 duty, 10 control |
| wr_data | input | 12 | Write data |
| pre_tick | input | 1 | Prescaler clock enable pulse |
| sw_trig | input | 1 | Software start pulse |
| ext_trig | input | 1 | Asynchronous external start pin |
| pwm_out | output | 1 | PWM output after polarity |

## Verification
The hardest situation to create is a buffered write made while the generator is running. Reaching it means landing a duty write in the middle of a period and then measuring the remainder of that period and the whole of the next one. The bench starts the generator from a known idle state and counts clock cycles from the start pulse. It places the write on a chosen counter step, well away from the wrap, so the old duty must hold until the boundary and the new duty must appear right after it. The selective external-edge cases are also awkward to reach. The bench sets the external pin to the level it needs while the stop bit holds the block, so that only the intended edge arrives once the block is released.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;

    typedef enum logic [1:0] {
        SEL_CYCLE = 2'b00,
        SEL_DUTY  = 2'b01,
        SEL_CTRL  = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_e;

    // packed MSB first: pol=bit5, div_sel=4:3, edge_sel=2:1, stop=bit0
    typedef struct packed {
        logic       pol;
        logic [1:0] div_sel;
        logic [1:0] edge_sel;
        logic       stop;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_trig_sync.sv
module pwm_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_in,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
    assign hit  = (edge_sel[0] & rise) | (edge_sel[1] & fall);
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] div_sel,
    output logic             adv
);
    localparam int PCW = (1 << SEL_W) - 1;

    logic [PCW-1:0] div_q;
    logic [PCW:0]   span;
    logic           last;

    assign span = {{PCW{1'b0}}, 1'b1} << div_sel;
    assign last = ({1'b0, div_q} == (span - 1'b1));
    assign adv  = tick_in && last && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (tick_in) begin
            div_q <= last ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_thru,
    input  logic             load,
    output logic [CNT_W-1:0] cyc_buf,
    output logic [CNT_W-1:0] duty_buf,
    output logic [CNT_W-1:0] cyc_act,
    output logic [CNT_W-1:0] duty_act,
    output ctrl_t            ctrl
);
    logic wr_cyc, wr_duty, wr_ctrl;

    assign wr_cyc  = wr_en && (reg_sel_e'(wr_sel) == SEL_CYCLE);
    assign wr_duty = wr_en && (reg_sel_e'(wr_sel) == SEL_DUTY);
    assign wr_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_buf  <= '0;
            duty_buf <= '0;
            cyc_act  <= '0;
            duty_act <= '0;
            ctrl     <= '0;
        end else begin
            if (load) begin
                cyc_act  <= cyc_buf;
                duty_act <= duty_buf;
            end
            if (wr_cyc) begin
                cyc_buf <= wr_data;
                if (wr_thru) cyc_act <= wr_data;
            end
            if (wr_duty) begin
                duty_buf <= wr_data;
                if (wr_thru) duty_act <= wr_data;
            end
            if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end
endmodule

// File: rtl/trig_pwm_gen.sv
module trig_pwm_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             pre_tick,
    input  logic             sw_trig,
    input  logic             ext_trig,
    output logic             pwm_out
);
    pwm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cyc_buf, duty_buf, cyc_act, duty_act, duty_nxt;
    ctrl_t            ctrl;
    logic             act_q, act_d;
    logic             ext_hit, start, boundary, load, adv, wr_thru, pre_clr;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wr_thru(wr_thru), .load(load),
        .cyc_buf(cyc_buf), .duty_buf(duty_buf), .cyc_act(cyc_act),
        .duty_act(duty_act), .ctrl(ctrl)
    );

    pwm_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_trig),
        .edge_sel(ctrl.edge_sel), .hit(ext_hit)
    );

    pwm_prescaler #(.SEL_W(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .tick_in(pre_tick),
        .div_sel(ctrl.div_sel), .adv(adv)
    );

    assign wr_thru  = (state_q == ST_IDLE) || ctrl.stop;
    assign start    = !ctrl.stop && (sw_trig || ext_hit);
    assign boundary = (state_q == ST_RUN) && !ctrl.stop && !start && adv
                      && (cnt_q == cyc_act);
    assign load     = start || boundary;
    assign pre_clr  = (state_d != ST_RUN) || start;
    assign duty_nxt = load ? duty_buf : duty_act;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = ctrl.stop ? ST_IDLE : ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (state_d == ST_IDLE || start || boundary) cnt_d = '0;
        else if (adv)                                 cnt_d = cnt_q + 1'b1;
        else                                          cnt_d = cnt_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    assign act_d = (state_d == ST_RUN) && (cnt_d < duty_nxt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    assign pwm_out = act_q ^ ctrl.pol;

    // R1
    idle_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !act_q);

    // R3
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && duty_act == '0) |-> !act_q);

    // R4
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && duty_act > cyc_act) |-> act_q);

    // R5
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !load && !wr_thru) |=> ($stable(cyc_act) && $stable(duty_act)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !adv && !start && !ctrl.stop) |=> $stable(cnt_q));

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= cyc_act));

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.stop |=> (state_q == ST_IDLE));
endmodule

// File: tb/trig_pwm_gen_tb.sv
module trig_pwm_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [11:0] wr_data = '0;
    logic        pre_tick = 1'b1;
    logic        sw_trig = 1'b0;
    logic        ext_trig = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    int highs;

    always #2.5 clk = ~clk;

    trig_pwm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pre_tick(pre_tick), .sw_trig(sw_trig),
        .ext_trig(ext_trig), .pwm_out(pwm_out)
    );

    // columns: period, duty, divide select, samples, expected active samples
    localparam int NVEC = 10;
    localparam int VEC [NVEC][5] = '{
        '{7,   3,  0, 16,  6},
        '{7,   0,  0,  8,  0},
        '{0,   0,  0,  4,  0},
        '{0,   1,  0,  4,  4},
        '{7,   8,  0,  8,  8},
        '{7,  12,  0,  8,  8},
        '{127, 1,  0, 128, 1},
        '{9,   4,  1, 20,  8},
        '{4,   2,  3, 40, 16},
        '{3,   3,  2, 16, 12}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [11:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    function automatic logic [11:0] cw(input bit pol, input int dv, input int eg, input bit stp);
        return {6'b0, pol, 2'(dv), 2'(eg), stp};
    endfunction

    task automatic setup(input int cyc, input int duty, input int dv, input int eg, input bit pol);
        wr(2'b10, cw(pol, dv, eg, 1'b1));
        wr(2'b00, 12'(cyc));
        wr(2'b01, 12'(duty));
        wr(2'b10, cw(pol, dv, eg, 1'b0));
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    // first sample at the current negedge
    task automatic measure(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            cnt += int'(pwm_out);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        chk(pwm_out == 1'b0, "R1 output during reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        wait_n(10);
        measure(5, highs);
        chk(highs == 0, "R1 idle after reset", highs, 0);
        setup(3, 4, 0, 0, 1'b0);
        wait_n(2);
        measure(6, highs);
        chk(highs == 0, "R1 no start without trigger", highs, 0);

        // table walk: R2 R3 R4 R6 R9
        for (int v = 0; v < NVEC; v++) begin
            setup(VEC[v][0], VEC[v][1], VEC[v][2], 0, 1'b0);
            pulse_trig();
            measure(VEC[v][3], highs);
            chk(highs == VEC[v][4], $sformatf("R2/R3/R4/R6/R9 row %0d", v), highs, VEC[v][4]);
        end

        // R5: buffered duty write in mid-period
        setup(7, 2, 0, 0, 1'b0);
        pulse_trig();
        begin
            int h1, h2;
            h1 = 0; h2 = 0;
            for (int i = 0; i < 16; i++) begin
                if (i > 0) @(negedge clk);
                if (i < 8) h1 += int'(pwm_out); else h2 += int'(pwm_out);
                if (i == 3) begin wr_en = 1'b1; wr_sel = 2'b01; wr_data = 12'd5; end
                if (i == 4) begin wr_en = 1'b0; wr_sel = 2'b11; end
            end
            chk(h1 == 2, "R5 old duty holds to period end", h1, 2);
            chk(h2 == 5, "R5 new duty next period", h2, 5);
        end

        // R9: no counting without pre_tick
        setup(7, 2, 0, 0, 1'b0);
        pre_tick = 1'b0;
        pulse_trig();
        measure(10, highs);
        chk(highs == 10, "R9 counter holds without pre_tick", highs, 10);
        pre_tick = 1'b1;
        @(negedge clk);
        measure(8, highs);
        chk(highs == 2, "R9 counting resumes", highs, 2);

        // R7: polarity
        setup(7, 3, 0, 0, 1'b1);
        wait_n(1);
        chk(pwm_out == 1'b1, "R7 inverted idle level", int'(pwm_out), 1);
        pulse_trig();
        measure(8, highs);
        chk(highs == 5, "R7 inverted duty", highs, 5);

        // R10: stop and ignored trigger
        setup(3, 4, 0, 0, 1'b0);
        pulse_trig();
        measure(4, highs);
        chk(highs == 4, "R10 running before stop", highs, 4);
        wr(2'b10, cw(1'b0, 0, 0, 1'b1));
        @(negedge clk);
        chk(pwm_out == 1'b0, "R10 stop forces inactive", int'(pwm_out), 0);
        pulse_trig();
        measure(6, highs);
        chk(highs == 0, "R10 trigger ignored while stopped", highs, 0);

        // R8: external edge selection
        setup(3, 4, 0, 0, 1'b0);
        @(negedge clk); ext_trig = 1'b1;
        wait_n(4);
        ext_trig = 1'b0;
        wait_n(5);
        measure(4, highs);
        chk(highs == 0, "R8 select 00 ignores pin", highs, 0);
        setup(3, 4, 0, 1, 1'b0);
        @(negedge clk); ext_trig = 1'b1;
        wait_n(5);
        measure(2, highs);
        chk(highs == 2, "R8 rising edge starts", highs, 2);
        wr(2'b10, cw(1'b0, 0, 2, 1'b1));
        ext_trig = 1'b0;
        wait_n(5);
        wr(2'b10, cw(1'b0, 0, 2, 1'b0));
        @(negedge clk); ext_trig = 1'b1;
        wait_n(5);
        measure(2, highs);
        chk(highs == 0, "R8 rising ignored on falling select", highs, 0);
        ext_trig = 1'b0;
        wait_n(5);
        measure(2, highs);
        chk(highs == 2, "R8 falling edge starts", highs, 2);
        wr(2'b10, cw(1'b0, 0, 3, 1'b1));
        wait_n(3);
        wr(2'b10, cw(1'b0, 0, 3, 1'b0));
        @(negedge clk); ext_trig = 1'b1;
        wait_n(5);
        measure(2, highs);
        chk(highs == 2, "R8 both-edge select starts on rise", highs, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule